// File: doc/BRIEF.md
# Partitioned Context-Tagged Translation Buffer

This block is a fully associative translation buffer with a configurable number of slots (at most 64). Each slot holds an aligned virtual page address, a 3-bit partition number, a context number, a flag that marks it as a real (context-free) mapping, a 2-bit page-size code, a lock flag, a recently-used flag, a valid flag and an aligned physical page address. A page-size code `s` makes the page span 2^(13+3s) bytes, so codes 0..3 give 8 KiB, 64 KiB, 512 KiB and 4 MiB pages.

The lookup port is purely combinational: the hit, the slot index and the translated physical address appear in the same cycle as the request. A lookup can also mark the hit slot as recently used at the next clock edge. Writes happen at the clock edge. An insert can name a slot or let the block pick a victim. A demap can drop a single page, a whole context or a whole partition. A diagnostic port returns a slot's tag word and data word by index. Page walks, fault reporting and register decoding belong to the surrounding logic.

Top module: `ctx_tlb`

## Requirements
- R1: A lookup hits only a slot that is valid, has the same partition and real flag, and whose page covers the address. The context must also match when the real flag is 0. On a hit, `lk_idx` is the slot and `lk_pa` is the slot's physical page ORed with the address's in-page offset. All three outputs settle in the same cycle as the request.
- R2: Page-size code s covers 2^(13+3s) bytes. Both the address match and the offset passed through to `lk_pa` use that span.
- R3: When `lk_upd_used` is 1, a hit sets the slot's used flag at the next edge. When it is 0, the flag does not change. The flag is visible as bit 61 of `rd_data`.
- R4: Before an insert is written, every valid slot with the same partition, context and real flag whose page overlaps the new page is invalidated. Such a slot counts as free for the choice of victim.
- R5: An automatic insert (`ins_explicit`=0) takes the lowest-numbered free slot. The new slot is valid and has its used flag set.
- R6: With no free slot, an automatic insert takes the lowest-numbered slot that is neither locked nor used.
- R7: If every unlocked slot is used, the insert first clears the used flag of all unlocked slots, then takes the lowest-numbered unlocked slot.
- R8: If every slot is valid and locked, an automatic insert overwrites the highest-numbered slot.
- R9: An insert with `ins_explicit`=1 writes slot `ins_idx`, after the overlap removal of R4.
- R10: Demap-page (`dm_op`=0) invalidates every slot that a lookup with the same address, partition, context and real flag would hit, whether or not the slot is locked.
- R11: Demap-context (`dm_op`=1) invalidates every valid slot with the given partition and context whose real flag is 0, locked or not. Slots with the real flag set are kept. Code 3 does nothing.
- R12: Demap-partition (`dm_op`=2) invalidates every valid, unlocked slot of the given partition and keeps the locked ones.
- R13: For a valid slot, `rd_tag` holds the partition in [63:61], the real flag in [60], the inverted 3-bit page-size code {0,s} in [58:56], the aligned virtual address in [VA_W-1:13] and the context in [12:0]. `rd_data` holds lock in [62], used in [61] and the aligned physical page in [PA_W-1:0]. An invalid slot reads all ones in both words.
- R14: When an insert and a demap arrive in the same cycle, the insert is performed and the demap is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; invalidates all slots |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_part | input | 3 | Lookup partition |
| lk_ctx | input | CTX_W | Lookup context |
| lk_real | input | 1 | Lookup is a real (context-free) access |
| lk_upd_used | input | 1 | Mark the hit slot as used |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Slot that hit |
| lk_pa | output | PA_W | Translated physical address (0 on miss) |
| ins_valid | input | 1 | Insert request |
| ins_explicit | input | 1 | Use `ins_idx` instead of automatic replacement |
| ins_idx | input | IDX_W | Slot for an explicit insert |
| ins_va | input | VA_W | New virtual page address |
| ins_part | input | 3 | New partition |
| ins_ctx | input | CTX_W | New context |
| ins_real | input | 1 | New real flag |
| ins_psz | input | 2 | New page-size code |
| ins_lock | input | 1 | New lock flag |
| ins_pa | input | PA_W | New physical page address |
| dm_valid | input | 1 | Demap request |
| dm_op | input | 2 | 0 page, 1 context, 2 partition, 3 none |
| dm_va | input | VA_W | Demap-page address |
| dm_part | input | 3 | Demap partition |
| dm_ctx | input | CTX_W | Demap context |
| dm_real | input | 1 | Demap-page real flag |
| rd_idx | input | IDX_W | Diagnostic slot index |
| rd_tag | output | 64 | Diagnostic tag word |
| rd_data | output | 64 | Diagnostic data word |

## Verification
The assertions check four things on every cycle:
- a lookup never matches more than one slot;
- a used-marking hit leaves its flag set;
- every insert leaves its chosen slot valid and used;
- a partition demap never removes a locked slot.

They also check that an all-locked buffer loses its last slot and that an empty slot reads as all ones. Only the bench scenarios can show the placement order of automatic inserts, the bulk clearing of used flags, overlap removal across page sizes, the exact tag and data layout, the context-ignoring match of real mappings, and the precedence of an insert over a demap in the same cycle.

// File: rtl/ctx_tlb.sv
module ctx_tlb #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int CTX_W   = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  input  logic [VA_W-1:0]     lk_va,
  input  logic [2:0]          lk_part,
  input  logic [CTX_W-1:0]    lk_ctx,
  input  logic                lk_real,
  input  logic                lk_upd_used,
  output logic                lk_hit,
  output logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] lk_idx,
  output logic [PA_W-1:0]     lk_pa,
  input  logic                ins_valid,
  input  logic                ins_explicit,
  input  logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] ins_idx,
  input  logic [VA_W-1:0]     ins_va,
  input  logic [2:0]          ins_part,
  input  logic [CTX_W-1:0]    ins_ctx,
  input  logic                ins_real,
  input  logic [1:0]          ins_psz,
  input  logic                ins_lock,
  input  logic [PA_W-1:0]     ins_pa,
  input  logic                dm_valid,
  input  logic [1:0]          dm_op,
  input  logic [VA_W-1:0]     dm_va,
  input  logic [2:0]          dm_part,
  input  logic [CTX_W-1:0]    dm_ctx,
  input  logic                dm_real,
  input  logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] rd_idx,
  output logic [63:0]         rd_tag,
  output logic [63:0]         rd_data
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int OFS   = 13;

  if (ENTRIES > 64 || ENTRIES < 2 || VA_W > 56 || VA_W < 23 ||
      PA_W > 56 || PA_W < 23 || CTX_W > 13 || CTX_W < 1) begin : g_bad_cfg
    $error("ctx_tlb: unsupported configuration");
  end

  function automatic logic [VA_W-1:0] va_span(input logic [1:0] s);
    return VA_W'((64'd1 << (OFS + 3 * int'(s))) - 64'd1);
  endfunction

  function automatic logic [PA_W-1:0] pa_span(input logic [1:0] s);
    return PA_W'((64'd1 << (OFS + 3 * int'(s))) - 64'd1);
  endfunction

  function automatic logic [IDX_W-1:0] lowest(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = ENTRIES - 1; k >= 0; k--)
      if (v[k]) r = IDX_W'(k);
    return r;
  endfunction

  logic [VA_W-1:0]  va_q   [ENTRIES];
  logic [PA_W-1:0]  pa_q   [ENTRIES];
  logic [2:0]       part_q [ENTRIES];
  logic [CTX_W-1:0] ctx_q  [ENTRIES];
  logic [1:0]       psz_q  [ENTRIES];
  logic [ENTRIES-1:0] real_q, lock_q, used_q, valid_q;
  logic [ENTRIES-1:0] valid_n, used_n;

  logic [ENTRIES-1:0] lk_m, cf, dm_pg, dm_cx, dm_al, kill;
  logic [ENTRIES-1:0] free_v, unl, fresh;
  logic [IDX_W-1:0]   victim;
  logic               bulk_clr, ins_go;
  logic [VA_W-1:0]    ins_va_al;

  assign ins_va_al = ins_va & ~va_span(ins_psz);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [VA_W-1:0] em;
    assign em = va_span(psz_q[i]);
    assign lk_m[i] = valid_q[i] && part_q[i] == lk_part && real_q[i] == lk_real &&
                     (lk_real || ctx_q[i] == lk_ctx) && ((lk_va ^ va_q[i]) & ~em) == '0;
    assign dm_pg[i] = valid_q[i] && part_q[i] == dm_part && real_q[i] == dm_real &&
                      (dm_real || ctx_q[i] == dm_ctx) && ((dm_va ^ va_q[i]) & ~em) == '0;
    assign dm_cx[i] = valid_q[i] && !real_q[i] && part_q[i] == dm_part && ctx_q[i] == dm_ctx;
    assign dm_al[i] = valid_q[i] && !lock_q[i] && part_q[i] == dm_part;
    assign cf[i]    = valid_q[i] && part_q[i] == ins_part && ctx_q[i] == ins_ctx &&
                      real_q[i] == ins_real &&
                      ((ins_va ^ va_q[i]) & ~(em | va_span(ins_psz))) == '0;
  end

  assign lk_hit = lk_valid && (|lk_m);
  assign lk_idx = lowest(lk_m);
  assign lk_pa  = lk_hit ? (pa_q[lk_idx] | (PA_W'(lk_va) & pa_span(psz_q[lk_idx]))) : '0;

  assign free_v = ~valid_q | cf;
  assign unl    = ~lock_q;
  assign fresh  = unl & ~used_q;

  always_comb begin
    bulk_clr = 1'b0;
    if (ins_explicit)     victim = ins_idx;
    else if (|free_v)     victim = lowest(free_v);
    else if (|fresh)      victim = lowest(fresh);
    else if (|unl) begin
      victim   = lowest(unl);
      bulk_clr = 1'b1;
    end else              victim = IDX_W'(ENTRIES - 1);
  end

  assign ins_go = ins_valid && (32'(victim) < ENTRIES);

  always_comb begin
    case (dm_op)
      2'd0:    kill = dm_pg;
      2'd1:    kill = dm_cx;
      2'd2:    kill = dm_al;
      default: kill = '0;
    endcase
  end

  always_comb begin
    valid_n = valid_q;
    used_n  = used_q;
    if (lk_hit && lk_upd_used) used_n[lk_idx] = 1'b1;
    if (ins_go) begin
      valid_n = valid_n & ~cf;
      used_n  = used_n & ~cf;
      if (bulk_clr) used_n = used_n & lock_q;
      valid_n[victim] = 1'b1;
      used_n[victim]  = 1'b1;
    end else if (dm_valid) begin
      valid_n = valid_n & ~kill;
      used_n  = used_n & ~kill;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      used_q  <= '0;
      real_q  <= '0;
      lock_q  <= '0;
      for (int k = 0; k < ENTRIES; k++) begin
        va_q[k]   <= '0;
        pa_q[k]   <= '0;
        part_q[k] <= '0;
        ctx_q[k]  <= '0;
        psz_q[k]  <= '0;
      end
    end else begin
      valid_q <= valid_n;
      used_q  <= used_n;
      if (ins_go) begin
        va_q[victim]   <= ins_va_al;
        pa_q[victim]   <= ins_pa & ~pa_span(ins_psz);
        part_q[victim] <= ins_part;
        ctx_q[victim]  <= ins_ctx;
        psz_q[victim]  <= ins_psz;
        real_q[victim] <= ins_real;
        lock_q[victim] <= ins_lock;
      end
    end
  end

  logic rd_ok;
  assign rd_ok = (32'(rd_idx) < ENTRIES) && valid_q[rd_idx];

  always_comb begin
    rd_tag  = '1;
    rd_data = '1;
    if (rd_ok) begin
      rd_tag              = '0;
      rd_tag[63:61]       = part_q[rd_idx];
      rd_tag[60]          = real_q[rd_idx];
      rd_tag[58:56]       = ~{1'b0, psz_q[rd_idx]};
      rd_tag[VA_W-1:OFS]  = va_q[rd_idx][VA_W-1:OFS];
      rd_tag[CTX_W-1:0]   = ctx_q[rd_idx];
      rd_data             = '0;
      rd_data[62]         = lock_q[rd_idx];
      rd_data[61]         = used_q[rd_idx];
      rd_data[PA_W-1:0]   = pa_q[rd_idx];
    end
  end

  p_single_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot0(lk_m));

  p_used_marked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_upd_used && !ins_valid && !dm_valid) |=> used_q[$past(lk_idx)]);

  p_insert_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_go |=> (valid_q[$past(victim)] && used_q[$past(victim)]));

  p_locked_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_explicit && (&lock_q) && (&valid_q) && !(|cf))
      |=> (va_q[ENTRIES-1] == $past(ins_va_al)));

  p_locked_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_valid && dm_op == 2'd2 && !ins_valid)
      |=> ((valid_q & $past(valid_q & lock_q)) == $past(valid_q & lock_q)));

  p_empty_reads_ones_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |-> (rd_tag == '1 && rd_data == '1));

endmodule

// File: tb/ctx_tlb_test.sv
`timescale 1ns/1ps
module ctx_tlb_test;
  localparam int N = 8;
  localparam int P = 8192;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, lk_real = 0, lk_upd_used = 0;
  logic [31:0] lk_va = 0;
  logic [2:0] lk_part = 0;
  logic [12:0] lk_ctx = 0;
  logic lk_hit;
  logic [2:0] lk_idx;
  logic [31:0] lk_pa;
  logic ins_valid = 0, ins_explicit = 0, ins_real = 0, ins_lock = 0;
  logic [2:0] ins_idx = 0, ins_part = 0;
  logic [31:0] ins_va = 0, ins_pa = 0;
  logic [12:0] ins_ctx = 0;
  logic [1:0] ins_psz = 0;
  logic dm_valid = 0, dm_real = 0;
  logic [1:0] dm_op = 0;
  logic [31:0] dm_va = 0;
  logic [2:0] dm_part = 0;
  logic [12:0] dm_ctx = 0;
  logic [2:0] rd_idx = 0;
  logic [63:0] rd_tag, rd_data;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ctx_tlb #(.ENTRIES(N), .VA_W(32), .PA_W(32), .CTX_W(13)) uut (.*);

  function automatic logic [63:0] tagw(int part, int rl, int psz, logic [31:0] va, int ctx);
    logic [2:0] ip;
    ip = ~(3'(psz));
    return (64'(part) << 61) | (64'(rl) << 60) | (64'(ip) << 56) | 64'(va) | 64'(ctx);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_tag_chk(input string req, input int idx, input logic [63:0] exp);
    rd_idx = 3'(idx);
    #1;
    chk(req, rd_tag, exp);
  endtask

  task automatic rd_data_chk(input string req, input int idx, input logic [63:0] exp);
    rd_idx = 3'(idx);
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic used_chk(input string req, input int idx, input bit exp);
    rd_idx = 3'(idx);
    #1;
    chk(req, 64'(rd_data[61]), 64'(exp));
  endtask

  task automatic set_ins(input logic [31:0] va, input int part, input int ctx, input bit rl,
                         input int psz, input bit lock, input logic [31:0] pa,
                         input bit expl, input int idx);
    ins_va = va; ins_part = 3'(part); ins_ctx = 13'(ctx); ins_real = rl;
    ins_psz = 2'(psz); ins_lock = lock; ins_pa = pa; ins_explicit = expl;
    ins_idx = 3'(idx); ins_valid = 1;
  endtask

  task automatic set_dm(input int op, input logic [31:0] va, input int part, input int ctx, input bit rl);
    dm_op = 2'(op); dm_va = va; dm_part = 3'(part); dm_ctx = 13'(ctx); dm_real = rl; dm_valid = 1;
  endtask

  task automatic ins(input logic [31:0] va, input int part, input int ctx, input bit rl,
                     input int psz, input bit lock, input logic [31:0] pa,
                     input bit expl, input int idx);
    @(negedge clk);
    set_ins(va, part, ctx, rl, psz, lock, pa, expl, idx);
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic dm(input int op, input logic [31:0] va, input int part, input int ctx, input bit rl);
    @(negedge clk);
    set_dm(op, va, part, ctx, rl);
    @(negedge clk);
    dm_valid = 0;
  endtask

  task automatic look(input string req, input logic [31:0] va, input int part, input int ctx,
                      input bit rl, input bit upd, input bit eh, input int ei, input logic [31:0] epa);
    @(negedge clk);
    lk_va = va; lk_part = 3'(part); lk_ctx = 13'(ctx); lk_real = rl; lk_upd_used = upd; lk_valid = 1;
    #1;
    chk(req, 64'(lk_hit), 64'(eh));
    if (eh) begin
      chk(req, 64'(lk_idx), 64'(ei));
      chk(req, 64'(lk_pa), 64'(epa));
    end
    if (upd) @(negedge clk);
    lk_valid = 0; lk_upd_used = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < N; i++) begin
      rd_tag_chk("R13 reset tag", i, '1);
      rd_data_chk("R13 reset data", i, '1);
    end
    look("R1 empty miss", 32'h0, 1, 5, 0, 0, 0, 0, 0);

    for (int i = 0; i < N; i++) begin
      ins(32'(i * P), 1, 5, 0, 0, 0, 32'((256 + i) * P), 0, 0);
      rd_tag_chk("R5 fill order", i, tagw(1, 0, 0, 32'(i * P), 5));
      rd_data_chk("R5 new entry used", i, (64'd1 << 61) | 64'((256 + i) * P));
    end

    for (int i = 0; i < N; i++)
      look("R1 hit sweep", 32'(i * P + 291), 1, 5, 0, 0, 1, i, 32'((256 + i) * P + 291));
    look("R1 wrong partition", 32'(3 * P), 2, 5, 0, 0, 0, 0, 0);
    look("R1 wrong context", 32'(3 * P), 1, 6, 0, 0, 0, 0, 0);
    look("R1 real flag differs", 32'(3 * P), 1, 5, 1, 0, 0, 0, 0);
    look("R1 uncovered page", 32'(8 * P), 1, 5, 0, 0, 0, 0, 0);

    ins(32'(8 * P), 1, 5, 0, 0, 0, 32'(300 * P), 0, 0);
    rd_tag_chk("R7 victim after bulk clear", 0, tagw(1, 0, 0, 32'(8 * P), 5));
    used_chk("R7 new entry used", 0, 1);
    for (int i = 1; i < N; i++) used_chk("R7 used cleared", i, 0);

    look("R3 hit no update", 32'(3 * P), 1, 5, 0, 0, 1, 3, 32'(259 * P));
    used_chk("R3 flag unchanged", 3, 0);
    look("R3 hit with update", 32'(3 * P + 7), 1, 5, 0, 1, 1, 3, 32'(259 * P + 7));
    used_chk("R3 flag set", 3, 1);

    ins(32'(9 * P), 1, 5, 0, 0, 0, 32'(301 * P), 0, 0);
    rd_tag_chk("R6 lowest unused", 1, tagw(1, 0, 0, 32'(9 * P), 5));
    rd_tag_chk("R6 used entry kept", 3, tagw(1, 0, 0, 32'(3 * P), 5));

    ins(32'h0, 1, 5, 0, 1, 0, 32'h0100_0000, 0, 0);
    rd_tag_chk("R4 overlap freed slot reused", 2, tagw(1, 0, 1, 32'h0, 5));
    for (int i = 3; i < N; i++) rd_tag_chk("R4 overlapping removed", i, '1);
    rd_tag_chk("R4 disjoint kept", 0, tagw(1, 0, 0, 32'(8 * P), 5));
    rd_tag_chk("R4 disjoint kept", 1, tagw(1, 0, 0, 32'(9 * P), 5));
    look("R2 64K page", 32'(5 * P + 16), 1, 5, 0, 0, 1, 2, 32'h0100_0000 + 32'(5 * P + 16));
    look("R1 small page", 32'(8 * P + 4), 1, 5, 0, 0, 1, 0, 32'(300 * P + 4));

    ins(32'(32 * P), 2, 7, 0, 0, 1, 32'(32'h555 * P), 1, 6);
    rd_tag_chk("R9 explicit slot tag", 6, tagw(2, 0, 0, 32'(32 * P), 7));
    rd_data_chk("R13 data layout", 6, (64'd1 << 62) | (64'd1 << 61) | 64'(32'h555 * P));
    ins(32'h0008_0000, 2, 9, 1, 2, 0, 32'h0200_0000, 1, 7);
    rd_tag_chk("R9 explicit real slot", 7, tagw(2, 1, 2, 32'h0008_0000, 9));
    look("R1 real ignores context", 32'h0008_1234, 2, 0, 1, 0, 1, 7, 32'h0200_1234);
    look("R2 512K page top", 32'h000F_FFFF, 2, 3, 1, 0, 1, 7, 32'h0207_FFFF);
    look("R2 past 512K page", 32'h0010_0000, 2, 9, 1, 0, 0, 0, 0);
    look("R1 real entry needs real access", 32'h0008_1234, 2, 9, 0, 0, 0, 0, 0);

    dm(1, 0, 1, 5, 0);
    for (int i = 0; i < 3; i++) rd_tag_chk("R11 context demapped", i, '1);
    rd_tag_chk("R11 other partition kept", 6, tagw(2, 0, 0, 32'(32 * P), 7));
    dm(1, 0, 2, 9, 0);
    rd_tag_chk("R11 real entry kept", 7, tagw(2, 1, 2, 32'h0008_0000, 9));
    dm(3, 0, 2, 7, 0);
    rd_tag_chk("R11 op3 no effect", 6, tagw(2, 0, 0, 32'(32 * P), 7));

    dm(0, 32'(32 * P), 2, 8, 0);
    rd_tag_chk("R10 wrong context kept", 6, tagw(2, 0, 0, 32'(32 * P), 7));
    dm(0, 32'(32 * P + 85), 2, 7, 0);
    rd_tag_chk("R10 locked page demapped", 6, '1);

    ins(32'(80 * P), 3, 1, 0, 0, 0, 32'(10 * P), 0, 0);
    ins(32'(81 * P), 3, 1, 0, 0, 1, 32'(11 * P), 0, 0);
    ins(32'(82 * P), 2, 1, 0, 0, 0, 32'(12 * P), 0, 0);
    rd_tag_chk("R5 lowest free", 0, tagw(3, 0, 0, 32'(80 * P), 1));
    rd_tag_chk("R5 lowest free", 1, tagw(3, 0, 0, 32'(81 * P), 1));
    rd_tag_chk("R5 lowest free", 2, tagw(2, 0, 0, 32'(82 * P), 1));
    dm(2, 0, 3, 0, 0);
    rd_tag_chk("R12 unlocked removed", 0, '1);
    rd_tag_chk("R12 locked kept", 1, tagw(3, 0, 0, 32'(81 * P), 1));
    rd_tag_chk("R12 other partition kept", 2, tagw(2, 0, 0, 32'(82 * P), 1));

    dm(2, 0, 2, 0, 0);
    rd_tag_chk("R12 partition cleared", 2, '1);
    rd_tag_chk("R12 real entry in partition cleared", 7, '1);
    for (int k = 0; k < 7; k++) ins(32'((256 + k) * P), 4, 2, 0, 0, 1, 32'(k * P), 0, 0);
    rd_tag_chk("R5 locked fill", 6, tagw(4, 0, 0, 32'(261 * P), 2));
    ins(32'(512 * P), 4, 2, 0, 0, 0, 32'(7 * P), 0, 0);
    rd_tag_chk("R8 all locked last slot", 7, tagw(4, 0, 0, 32'(512 * P), 2));
    rd_data_chk("R8 replaced unlocked", 7, (64'd1 << 61) | 64'(7 * P));
    rd_tag_chk("R8 neighbour kept", 6, tagw(4, 0, 0, 32'(261 * P), 2));

    @(negedge clk);
    set_ins(32'(768 * P), 1, 3, 0, 0, 0, 32'(9 * P), 1, 0);
    set_dm(0, 32'(512 * P), 4, 2, 0);
    @(negedge clk);
    ins_valid = 0; dm_valid = 0;
    rd_tag_chk("R14 insert performed", 0, tagw(1, 0, 0, 32'(768 * P), 3));
    rd_tag_chk("R14 demap dropped", 7, tagw(4, 0, 0, 32'(512 * P), 2));
    dm(0, 32'(512 * P), 4, 2, 0);
    rd_tag_chk("R10 demap alone applies", 7, '1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule